// File: doc/BRIEF.md
# Page-Mode ROM Read Port

This block is a clock-cycle model of the read side of a one-time-programmable memory with 16-bit words. A word address, an active-low chip select and an active-low output enable control access. A mode pin chooses between full-word output and byte output. In byte mode a separate byte-select input picks which half of the stored word goes onto the low lane. Each lane has its own drive-enable, so a wrapper can turn the outputs into tristate pins.

Access time is counted in clock cycles. After any ordinary address change, or after the chip becomes selected, the fetch takes a long count. Once a fetch has finished, moving to another word inside the same aligned 8-word page takes a shorter count. The `dvalid` output goes high when the count ends and stays high until the next access begins.

A separate flag models a high voltage on one address line. When that flag is set and the address is 0 or 1, the port returns fixed identifier words instead of array data. The array resets to the erased pattern (all ones). The bench fills it through a load port.

Top module: `page_rom_rd`

## Requirements
- R1: While `ce_n` is 1, `q_lo_en`, `q_hi_en` and `q15_en` are all 0. `dvalid` is 0 from the first clock edge that sees `ce_n` high.
- R2: While `ce_n` is 0 and `oe_n` is 1, all three lane enables are 0 and `dvalid` is unaffected. With both at 0, `q_lo_en` is 1.
- R3: In word mode (`wide`=1) with outputs enabled, `q_lo` carries stored bits 7:0, `q_hi` carries bits 14:8 and `q15` carries bit 15, and all three enables are 1.
- R4: In byte mode (`wide`=0), `q_hi_en` and `q15_en` are 0. `q_lo` shows stored bits 15:8 when the `byte_sel` value captured with the data was 1, and bits 7:0 when it was 0.
- R5: A full access raises `dvalid` exactly NORM_LAT clock edges after the edge that first sees the new address (or sees `ce_n` low).
- R6: After a completed access, a change confined to `addr[2:0]` (and `byte_sel` in byte mode), with `wide` and `id_hv` unchanged, raises `dvalid` after PAGE_LAT edges.
- R7: A change in `addr` above bit 2, in `wide` or in `id_hv`, and any access after `ce_n` was high, takes the full NORM_LAT count.
- R8: While a count is running, `dvalid` is 0 and the lanes hold the previously fetched data.
- R9: With `id_hv`=1 and `addr[AW-1:1]`=0, the fetched word is 16'h00C2 for `addr[0]`=0 and 16'hB800 for `addr[0]`=1.
- R10: With `id_hv`=1 and any of `addr[AW-1:1]` nonzero, array data is returned.
- R11: After reset, every array word reads 16'hFFFF until it is loaded, and `dvalid` is 0.
- R12: In word mode, a change on `byte_sel` alone starts no access: `dvalid` stays 1 and `q_lo` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ld_en | input | 1 | Array load strobe |
| ld_addr | input | AW | Array load address |
| ld_data | input | 16 | Array load data |
| addr | input | AW | Word address |
| id_hv | input | 1 | Identifier-mode high-voltage flag |
| byte_sel | input | 1 | Byte select (byte mode only) |
| wide | input | 1 | 1 = word mode, 0 = byte mode |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| q_lo | output | 8 | Low data lane |
| q_lo_en | output | 1 | Low lane drive enable |
| q_hi | output | 7 | Data bits 14:8 |
| q_hi_en | output | 1 | Bits 14:8 drive enable |
| q15 | output | 1 | Data bit 15 |
| q15_en | output | 1 | Bit 15 drive enable |
| dvalid | output | 1 | Fetched data valid |

## Verification
Accesses are issued in sequence and compared on both latency and lane contents, so each sequence shows whether the block took the page path or the full path. Several patterns are used:

- stepping within one page in word mode;
- jumping to another page;
- toggling the byte select inside a page in byte mode;
- switching modes;
- reselecting the chip after standby;
- raising the identifier flag with both zero and nonzero upper address bits.

Besides the latency, these patterns check whether steering follows the captured byte select, whether identifier decoding depends on the upper address bits, and that neither a byte-select toggle in word mode nor the output enable starts an access.

// File: rtl/page_rom_rd.sv
module page_rom_rd #(
  parameter int AW       = 8,
  parameter int NORM_LAT = 9,
  parameter int PAGE_LAT = 5,
  parameter logic [15:0] MFR_WORD = 16'h00C2,
  parameter logic [15:0] DEV_WORD = 16'hB800
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_addr,
  input  logic [15:0]   ld_data,
  input  logic [AW-1:0] addr,
  input  logic          id_hv,
  input  logic          byte_sel,
  input  logic          wide,
  input  logic          ce_n,
  input  logic          oe_n,
  output logic [7:0]    q_lo,
  output logic          q_lo_en,
  output logic [6:0]    q_hi,
  output logic          q_hi_en,
  output logic          q15,
  output logic          q15_en,
  output logic          dvalid
);
  localparam int DEPTH = 1 << AW;
  localparam int KW    = AW + 3;
  localparam int CW    = $clog2(NORM_LAT + 1);

  logic [15:0]   mem [DEPTH];
  logic [KW-1:0] key_q;
  logic          ce_q;
  logic [CW-1:0] cnt;
  logic          page_open;
  logic [15:0]   word_q;
  logic          bsel_q;

  wire [KW-1:0] key_now  = {wide, id_hv, wide ? 1'b0 : byte_sel, addr};
  wire          same_pg  = (addr[AW-1:3] == key_q[AW-1:3]) &&
                           (key_now[KW-1:KW-2] == key_q[KW-1:KW-2]);
  wire          page_hit = page_open && same_pg;
  wire          start    = !ce_n && (!ce_q || key_now != key_q);
  wire          id_match = id_hv && (addr[AW-1:1] == '0);
  wire [15:0]   fetched  = id_match ? (addr[0] ? DEV_WORD : MFR_WORD) : mem[addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (ld_en) begin
      mem[ld_addr] <= ld_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_q     <= '0;
      ce_q      <= 1'b0;
      cnt       <= '0;
      page_open <= 1'b0;
      dvalid    <= 1'b0;
      word_q    <= '1;
      bsel_q    <= 1'b0;
    end else begin
      key_q <= key_now;
      ce_q  <= !ce_n;
      if (ce_n) begin
        cnt       <= '0;
        dvalid    <= 1'b0;
        page_open <= 1'b0;
      end else if (start) begin
        cnt    <= page_hit ? CW'(PAGE_LAT) : CW'(NORM_LAT);
        dvalid <= 1'b0;
        if (!page_hit) page_open <= 1'b0;
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          dvalid    <= 1'b1;
          page_open <= 1'b1;
          word_q    <= fetched;
          bsel_q    <= byte_sel;
        end
      end
    end
  end

  wire drive = !ce_n && !oe_n;

  assign q_lo_en = drive;
  assign q_hi_en = drive && wide;
  assign q15_en  = drive && wide;
  assign q_lo    = (!wide && bsel_q) ? word_q[15:8] : word_q[7:0];
  assign q_hi    = word_q[14:8];
  assign q15     = word_q[15];
endmodule

// File: rtl/page_rom_rd_chk.sv
module page_rom_rd_chk (
  input logic clk,
  input logic rst_n,
  input logic ce_n,
  input logic oe_n,
  input logic wide,
  input logic q_lo_en,
  input logic q_hi_en,
  input logic q15_en,
  input logic dvalid
);
  a_r1_standby_float: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> (!q_lo_en && !q_hi_en && !q15_en));

  a_r1_standby_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> !dvalid);

  a_r2_out_disable: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && oe_n) |-> (!q_lo_en && !q_hi_en && !q15_en));

  a_r4_byte_hi_float: assert property (@(posedge clk) disable iff (!rst_n)
    !wide |-> (!q_hi_en && !q15_en));

  a_r7_valid_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dvalid) |-> $past(!ce_n));
endmodule

bind page_rom_rd page_rom_rd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .wide(wide),
  .q_lo_en(q_lo_en), .q_hi_en(q_hi_en), .q15_en(q15_en), .dvalid(dvalid)
);

// File: tb/page_rom_rd_tb.sv
module page_rom_rd_tb_top;
  localparam int CLK_NS = 10;
  localparam int AW = 8;
  localparam int NL = 9;
  localparam int PL = 5;

  logic clk = 0, rst_n = 0;
  logic ld_en = 0;
  logic [AW-1:0] ld_addr = '0, addr = '0;
  logic [15:0] ld_data = '0;
  logic id_hv = 0, byte_sel = 0, wide = 1, ce_n = 1, oe_n = 1;
  logic [7:0] q_lo;
  logic [6:0] q_hi;
  logic q_lo_en, q_hi_en, q15, q15_en, dvalid;

  page_rom_rd #(.AW(AW), .NORM_LAT(NL), .PAGE_LAT(PL)) dut_i (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .addr(addr), .id_hv(id_hv), .byte_sel(byte_sel), .wide(wide), .ce_n(ce_n), .oe_n(oe_n),
    .q_lo(q_lo), .q_lo_en(q_lo_en), .q_hi(q_hi), .q_hi_en(q_hi_en),
    .q15(q15), .q15_en(q15_en), .dvalid(dvalid));

  always #(CLK_NS/2) clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int start; int lat; logic [15:0] w; logic wmode; logic bs; string tag;
  } item_t;
  item_t sb[$];

  function automatic logic [15:0] pat(input int a);
    return {8'(a) ^ 8'hA5, 8'(a)};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic dv_prev = 0;
  always @(negedge clk) begin
    if (rst_n && dvalid && !dv_prev && sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      chk(cyc - it.start - 1 == it.lat, {it.tag, " latency"}, cyc - it.start - 1, it.lat);
      if (it.wmode) begin
        chk({q15, q_hi, q_lo} == it.w, {it.tag, " R3 word lanes"}, {q15, q_hi, q_lo}, it.w);
        chk(q_lo_en && q_hi_en && q15_en, {it.tag, " R3 enables"}, {q_lo_en, q_hi_en, q15_en}, 3'b111);
      end else begin
        chk(q_lo == (it.bs ? it.w[15:8] : it.w[7:0]), {it.tag, " R4 byte steer"}, q_lo,
            it.bs ? it.w[15:8] : it.w[7:0]);
        chk(q_lo_en && !q_hi_en && !q15_en, {it.tag, " R4 upper float"}, {q_lo_en, q_hi_en, q15_en}, 3'b100);
      end
    end
    dv_prev = dvalid;
  end

  task automatic push(input int a, input bit hv, input bit bs, input bit wm,
                      input logic [15:0] w, input int lat, input string tag);
    item_t it;
    @(negedge clk);
    addr = AW'(a); id_hv = hv; byte_sel = bs; wide = wm; ce_n = 0; oe_n = 0;
    it.start = cyc; it.lat = lat; it.w = w; it.wmode = wm; it.bs = bs; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (sb.size() > 0 && n < 200) begin @(negedge clk); n++; end
    if (sb.size() > 0) begin
      chk(0, {tag, " timeout"}, 0, 1);
      sb.delete();
    end
    @(negedge clk);
  endtask

  task automatic req(input int a, input bit hv, input bit bs, input bit wm,
                     input logic [15:0] w, input int lat, input string tag);
    push(a, hv, bs, wm, w, lat, tag);
    wait_done(tag);
  endtask

  initial begin
    #(CLK_NS * 150000);
    chk(0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!dvalid && !q_lo_en && !q_hi_en && !q15_en, "R11 R1 reset state", {dvalid, q_lo_en}, 0);
    rst_n = 1;
    for (int i = 0; i < 256; i++) begin
      if (i != 8'h80) begin
        @(negedge clk); ld_en = 1; ld_addr = AW'(i); ld_data = pat(i);
      end
    end
    @(negedge clk); ld_en = 0;

    req(8'h10, 0, 0, 1, pat(8'h10), NL, "R5 first full access");
    req(8'h13, 0, 0, 1, pat(8'h13), PL, "R6 page hit");
    req(8'h17, 0, 0, 1, pat(8'h17), PL, "R6 page hit end");
    req(8'h20, 0, 0, 1, pat(8'h20), NL, "R7 new page");

    byte_sel = 1;
    repeat (3) @(negedge clk);
    chk(dvalid && q_lo == 8'h20, "R12 byte_sel ignored in word mode", {dvalid, q_lo}, {1'b1, 8'h20});

    req(8'h20, 0, 1, 0, pat(8'h20), NL, "R7 mode change");
    req(8'h20, 0, 0, 0, pat(8'h20), PL, "R6 byte page low");
    req(8'h21, 0, 1, 0, pat(8'h21), PL, "R6 byte page high");
    req(8'h80, 0, 0, 1, 16'hFFFF, NL, "R11 erased word");

    ce_n = 1;
    @(negedge clk);
    chk(!dvalid && !q_lo_en && !q_hi_en && !q15_en, "R1 standby", {dvalid, q_lo_en, q_hi_en, q15_en}, 0);
    req(8'h81, 0, 0, 1, pat(8'h81), NL, "R7 reselect closes page");

    oe_n = 1;
    @(negedge clk);
    chk(dvalid && !q_lo_en && !q_hi_en && !q15_en, "R2 output disable", {dvalid, q_lo_en, q_hi_en, q15_en}, 4'b1000);
    oe_n = 0;
    @(negedge clk);
    chk(q_lo_en, "R2 output enable", q_lo_en, 1);

    req(8'h00, 1, 0, 1, 16'h00C2, NL, "R9 maker code");
    req(8'h01, 1, 0, 1, 16'hB800, PL, "R9 device code");
    req(8'h12, 1, 0, 1, pat(8'h12), NL, "R10 flag with upper bits");

    push(8'h30, 0, 0, 1, pat(8'h30), NL, "R8 hold");
    repeat (3) @(negedge clk);
    chk(!dvalid && q_lo == 8'h12, "R8 hold during count", {dvalid, q_lo}, {1'b0, 8'h12});
    wait_done("R8 hold");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule